// File: doc/BRIEF.md
# Overflow-Set / Match-Clear PWM Timer

This block is an 8-bit free-running counter that produces a pulse-width-modulated waveform. The counter advances once per count-clock strobe, which comes from an external prescaler. The waveform goes high each time the counter rolls from its top value back to zero. It goes low when the counter reaches a programmable compare value. The counter never restarts on a match, so every period is exactly 256 strobes long. The compare value sets the duty cycle: N strobes high out of 256.

Each compare match also raises a one-clock interrupt pulse. Software brings the timer up in a fixed order. First it stops the counter and disables the pin. Then it writes the compare value, selects the PWM mode and the count clock, enables the pin, and finally starts counting. While the pin is disabled it shows the idle port level, which is 0.

Top module: `pwm_ovf_timer`

## Requirements
- R1: After reset the pin is low, the interrupt is low, the counter is 00H and the compare register is 00H.
- R2: While `runEn` and `pwmMode` are both 1, each cycle with `cntStrobe` high advances the counter by one. The counter rolls from FFH to 00H, so the interrupt repeats every 256 strobes.
- R3: On the strobe that rolls the counter from FFH to 00H, the PWM state goes high, provided the compare value is not 00H.
- R4: On the strobe that brings the counter to the compare value, the PWM state goes low and `irqPulse` is high for exactly the next clock cycle. The counter keeps counting through the match.
- R5: With a compare value of 00H, the rollover and the match fall on the same strobe. The match wins, so the PWM state stays low and the interrupt still fires once per rollover.
- R6: While `runEn` or `pwmMode` is 0, the counter is held at 00H, the PWM state is low and no interrupt fires. After a restart the first match comes N strobes later.
- R7: A write on `cmpWrEn` loads `cmpWrData` into the compare register only while `runEn` is 0. A write made while running is ignored.
- R8: `pwmPin` shows the PWM state when `outEn` is 1 and shows 0 when `outEn` is 0. The PWM state keeps evolving while the pin is disabled.
- R9: The counter, the PWM state and the interrupt change only on clock cycles where `cntStrobe` is high. The one exception is the forced idle of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntStrobe | input | 1 | One-clock count-clock enable from the prescaler |
| runEn | input | 1 | Count enable; 0 stops the counter and clears it |
| pwmMode | input | 1 | 1 selects the PWM mode; 0 keeps the timer idle |
| outEn | input | 1 | Pin enable; 0 drives the idle level 0 |
| cmpWrEn | input | 1 | Compare register write strobe |
| cmpWrData | input | 8 | Compare value to write |
| pwmPin | output | 1 | PWM waveform |
| irqPulse | output | 1 | One-clock compare-match interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- the interrupt never lasts more than one clock;
- nothing moves on a cycle without a strobe;
- the idle state is forced while stopped;
- the compare register stays frozen while running;
- the output rises on a rollover and falls on a match;
- the state stays low whenever the compare value is 00H.

Other behaviour only the bench scenarios can show. These include the 256-strobe period and the N-strobe high time for several compare values, including 01H and FFH. They also include the restart phase after a stop or a mode change, and that a running write really leaves the duty unchanged. A cycle-accurate reference model in the bench predicts the pin and the interrupt for every cycle, including sparse strobe patterns and periods with the pin disabled.

// File: rtl/pwm_ovf_pkg.sv
package pwm_ovf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntStep;  // advance counter by one
    logic cntZero;  // force counter to zero
    logic cmpLoad;  // capture compare write data
  } dpCtlT;

  // Status from datapath to control, describing the next count value
  typedef struct packed {
    logic wrapNext;   // counter is at its top; next step rolls to zero
    logic matchNext;  // next count value equals compare register
  } dpStatT;

endpackage

// File: rtl/pwm_ovf_datapath.sv
module pwm_ovf_datapath
  import pwm_ovf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtlT            ctl,
  input  logic [CNT_W-1:0] cmpWrData,
  output dpStatT           stat,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] eqBits;

  assign cntNext = cntQ + 1'b1;

  // Bitwise equality of the next count against the compare register
  for (genvar b = 0; b < CNT_W; b++) begin : gEq
    assign eqBits[b] = ~(cntNext[b] ^ cmpQ[b]);
  end

  assign stat.matchNext = &eqBits;
  assign stat.wrapNext  = (cntQ == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.cntZero) begin
      cntQ <= '0;
    end else if (ctl.cntStep) begin
      cntQ <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (ctl.cmpLoad) begin
      cmpQ <= cmpWrData;
    end
  end

  AST_STEP_FROM_TOP_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cntStep && !ctl.cntZero && cntQ == CNT_TOP) |=> (cntQ == '0)); // R2

  AST_ZERO_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntZero |=> (cntQ == '0)); // R6

endmodule

// File: rtl/pwm_ovf_ctrl.sv
module pwm_ovf_ctrl
  import pwm_ovf_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cntStrobe,
  input  logic   runEn,
  input  logic   pwmMode,
  input  logic   cmpWrEn,
  input  dpStatT stat,
  output dpCtlT  ctl,
  output logic   pwmState,
  output logic   irqPulse
);

  logic active;

  assign active      = runEn & pwmMode;
  assign ctl.cntZero = ~active;
  assign ctl.cntStep = active & cntStrobe;
  assign ctl.cmpLoad = cmpWrEn & ~runEn;

  // Match has priority over rollover
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmState <= 1'b0;
      irqPulse <= 1'b0;
    end else if (!active) begin
      pwmState <= 1'b0;
      irqPulse <= 1'b0;
    end else if (cntStrobe) begin
      irqPulse <= stat.matchNext;
      if (stat.matchNext) begin
        pwmState <= 1'b0;
      end else if (stat.wrapNext) begin
        pwmState <= 1'b1;
      end
    end else begin
      irqPulse <= 1'b0;
    end
  end

  AST_WRAP_SETS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (active && cntStrobe && stat.wrapNext && !stat.matchNext) |=> pwmState); // R3

  AST_MATCH_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (active && cntStrobe && stat.matchNext) |=> (!pwmState && irqPulse)); // R4

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R4

endmodule

// File: rtl/pwm_ovf_timer.sv
module pwm_ovf_timer
  import pwm_ovf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntStrobe,
  input  logic             runEn,
  input  logic             pwmMode,
  input  logic             outEn,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  output logic             pwmPin,
  output logic             irqPulse
);

  dpCtlT            ctl;
  dpStatT           stat;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic             pwmState;

  pwm_ovf_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmpWrData (cmpWrData),
    .stat      (stat),
    .cntQ      (cntQ),
    .cmpQ      (cmpQ)
  );

  pwm_ovf_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntStrobe (cntStrobe),
    .runEn     (runEn),
    .pwmMode   (pwmMode),
    .cmpWrEn   (cmpWrEn),
    .stat      (stat),
    .ctl       (ctl),
    .pwmState  (pwmState),
    .irqPulse  (irqPulse)
  );

  // Idle port level is 0 while the pin is disabled
  assign pwmPin = outEn & pwmState;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(runEn && pwmMode) |=> (cntQ == '0 && !pwmState && !irqPulse)); // R6

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && pwmMode && !cntStrobe) |=> ($stable(cntQ) && $stable(pwmState) && !irqPulse)); // R9

  AST_CMP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> $stable(cmpQ)); // R7

  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmpQ == '0) |-> !pwmState); // R5

endmodule

// File: tb/pwm_ovf_timer_test.sv
module pwm_ovf_timer_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  pin;
    logic  irq;
    string tag;
  } expT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntStrobe = 1'b0;
  logic       runEn = 1'b0;
  logic       pwmMode = 1'b0;
  logic       outEn = 1'b0;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = 8'h00;
  logic       pwmPin;
  logic       irqPulse;

  int checks = 0;
  int failures = 0;
  expT expQ[$];

  // Reference model state
  logic [7:0] mCnt = 8'h00;
  logic [7:0] mCmp = 8'h00;
  logic       mSt = 1'b0;

  pwm_ovf_timer uut (
    .clk(clk), .rstN(rstN), .cntStrobe(cntStrobe), .runEn(runEn),
    .pwmMode(pwmMode), .outEn(outEn), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .pwmPin(pwmPin), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: apply one cycle of stimulus, predict, push expectation
  task automatic tick(input logic stb, input logic run, input logic mode,
                      input logic oe, input logic wr, input logic [7:0] wd,
                      input string tag);
    expT e;
    logic [7:0] n;
    logic irqM;
    @(negedge clk);
    cntStrobe = stb; runEn = run; pwmMode = mode; outEn = oe;
    cmpWrEn = wr; cmpWrData = wd;
    irqM = 1'b0;
    if (!run || !mode) begin
      mCnt = 8'h00; mSt = 1'b0;
    end else if (stb) begin
      n = mCnt + 8'h01;
      if (n == 8'h00) mSt = 1'b1;
      if (n == mCmp) begin mSt = 1'b0; irqM = 1'b1; end
      mCnt = n;
    end
    if (wr && !run) mCmp = wd;
    e.pin = oe & mSt; e.irq = irqM; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic runSeq(input int n, input int per, input logic run,
                        input logic mode, input logic oe, input string tag);
    for (int i = 0; i < n; i++)
      tick((i % per) == per - 1, run, mode, oe, 1'b0, 8'h00, tag);
  endtask

  task automatic loadCmp(input logic [7:0] v, input string tag);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, v, tag);
  endtask

  // Monitor: pop and compare after each active edge
  initial begin
    expT e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (pwmPin !== e.pin || irqPulse !== e.irq) begin
          failures++;
          $display("FAIL %s pin/irq actual=%b/%b expected=%b/%b at %0t",
                   e.tag, pwmPin, irqPulse, e.pin, e.irq, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (pwmPin !== 1'b0 || irqPulse !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset pin/irq actual=%b/%b expected=0/0", pwmPin, irqPulse);
    end
    rstN = 1'b1;
    // R1 compare resets to 00H: behaves as the R5 case
    runSeq(300, 1, 1'b1, 1'b1, 1'b1, "R1 R5");
    runSeq(2, 1, 1'b0, 1'b1, 1'b1, "R6");
    loadCmp(8'h40, "R7");
    // R2 R3 R4: continuous strobes, duty 64/256
    runSeq(600, 1, 1'b1, 1'b1, 1'b1, "R2 R3 R4");
    // R7: write while running is ignored
    tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h10, "R7");
    runSeq(300, 1, 1'b1, 1'b1, 1'b1, "R7");
    // R9: sparse strobes
    runSeq(900, 3, 1'b1, 1'b1, 1'b1, "R9");
    // R8: pin disabled then re-enabled while running
    runSeq(300, 1, 1'b1, 1'b1, 1'b0, "R8");
    runSeq(100, 1, 1'b1, 1'b1, 1'b1, "R8");
    // R6: mode off forces idle, restart from 00H
    runSeq(20, 1, 1'b1, 1'b0, 1'b1, "R6");
    runSeq(300, 1, 1'b1, 1'b1, 1'b1, "R6");
    // R4 boundary compare values
    runSeq(2, 1, 1'b0, 1'b1, 1'b1, "R6");
    loadCmp(8'hFF, "R4");
    runSeq(520, 1, 1'b1, 1'b1, 1'b1, "R4");
    runSeq(2, 1, 1'b0, 1'b1, 1'b1, "R6");
    loadCmp(8'h01, "R4");
    runSeq(520, 1, 1'b1, 1'b1, 1'b1, "R4");
    // R5: compare 00H keeps state low
    runSeq(2, 1, 1'b0, 1'b1, 1'b1, "R6");
    loadCmp(8'h00, "R5");
    runSeq(520, 1, 1'b1, 1'b1, 1'b1, "R5");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule